// File: doc/BRIEF.md
# Modulo-3 Running-Sum Accumulator

This block keeps a running total of unsigned operands reduced modulo 3. On every rising clock edge where the accumulate enable is high, the operand is added to the stored residue. The remainder after division by 3 becomes the new stored value. With the enable low, the stored value is kept.

The stored residue is itself the output, so the output is fully registered and can change only at a clock edge. A residue takes one of three values, so one of the four codes of the 2-bit register is never used. If that code ever appears, the register returns to zero on the next edge.

Top module: `tri_residue_acc`

## Requirements
- R1: A synchronous active-high reset sets the residue to 0 at the next rising edge. Reset takes priority over the enable.
- R2: With the enable high, each rising edge loads (previous residue + operand) mod 3. The operand is an unsigned 2-bit number.
- R3: An operand of 3 (binary 11) with the enable high leaves the residue unchanged.
- R4: With the enable low, the residue holds its value at every edge, whatever the operand is.
- R5: The residue port is driven straight from the state register. A change of the inputs between edges does not move it.
- R6: The residue port never shows code 11. If the register holds 11, the next edge loads 00.
- R7: The sum wraps at 3, not at 4. For example, 2 + 2 gives 1 and 2 + 1 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Add the operand at this edge when high |
| operand | input | OP_W (2) | Unsigned value to add |
| residue | output | 2 | Stored sum modulo 3 (0, 1 or 2) |

## Verification
A fixed vector walk starts from zero. It steps through single increments that wrap from 2 to 0, double increments that wrap from 2 to 1, and operands of 3. These separate a true mod-3 adder from a plain 2-bit adder, and from an adder that reduces the operand wrongly.

Vectors with the enable low and a non-zero operand show whether the hold path ignores the operand. A reset applied together with an active enable shows whether reset has priority. Inputs are changed between edges to check that the output is registered.

A long random stream is then compared against a model that sums all enabled operands since reset. This covers every pairing of residue and operand.

// File: rtl/tri_pkg.sv
package tri_pkg;
  localparam int RES_W   = 2;
  localparam int MODULUS = 3;
  typedef logic [RES_W-1:0] res_t;
  localparam res_t RES_ZERO   = res_t'(0);
  localparam res_t RES_UNUSED = res_t'(3);
endpackage

// File: rtl/tri_mod_add.sv
module tri_mod_add
  import tri_pkg::*;
#(
  parameter int OP_W = 2
) (
  input  res_t            cur,
  input  logic [OP_W-1:0] op,
  output res_t            nxt
);
  localparam int SW = (OP_W > RES_W ? OP_W : RES_W) + 1;

  logic [SW-1:0] op_red;
  logic [SW-1:0] sum;

  // Reduce the operand first, so the sum stays below 2*MODULUS
  assign op_red = SW'(op) % SW'(MODULUS);
  assign sum    = SW'(cur) + op_red;
  assign nxt    = (sum >= SW'(MODULUS)) ? res_t'(sum - SW'(MODULUS)) : res_t'(sum);
endmodule

// File: rtl/tri_state_reg.sv
module tri_state_reg
  import tri_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  res_t d,
  output res_t q
);
  always_ff @(posedge clk) begin
    if (rst)                    q <= RES_ZERO;
    else if (q == RES_UNUSED)   q <= RES_ZERO;
    else if (load)              q <= d;
  end

  // R1: reset clears the register
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> q == RES_ZERO);

  // R4: no load means no change
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && q != RES_UNUSED) |=> $stable(q));

  // R6: unused code never seen while running
  a_r6_no_unused: assert property (@(posedge clk) disable iff (rst) q != RES_UNUSED);
endmodule

// File: rtl/tri_residue_acc.sv
module tri_residue_acc
  import tri_pkg::*;
#(
  parameter int OP_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_en,
  input  logic [OP_W-1:0] operand,
  output logic [1:0]      residue
);
  res_t state_q;
  res_t state_d;

  tri_mod_add #(.OP_W(OP_W)) u_add (
    .cur (state_q),
    .op  (operand),
    .nxt (state_d)
  );

  tri_state_reg u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (acc_en),
    .d    (state_d),
    .q    (state_q)
  );

  assign residue = state_q;

  // R2: enabled edge loads (old + operand) mod 3
  a_r2_mod_step: assert property (@(posedge clk) disable iff (rst)
    (acc_en && residue != RES_UNUSED) |=>
      int'(residue) == (int'($past(residue)) + int'($past(operand))) % MODULUS);

  // R3: operand of 3 leaves the residue unchanged
  a_r3_three_neutral: assert property (@(posedge clk) disable iff (rst)
    (acc_en && int'(operand) == 3 && residue != RES_UNUSED) |=> $stable(residue));
endmodule

// File: tb/tri_residue_acc_test.sv
`timescale 1ns/1ps
module tri_residue_acc_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       acc_en;
  logic [1:0] operand;
  logic [1:0] residue;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tri_residue_acc #(.OP_W(2)) uut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .operand(operand), .residue(residue)
  );

  // {en, operand, expected residue after the edge}
  localparam int NV = 16;
  localparam logic [4:0] VEC [NV] = '{
    {1'b1, 2'd1, 2'd1}, {1'b1, 2'd1, 2'd2}, {1'b1, 2'd1, 2'd0}, {1'b1, 2'd2, 2'd2},
    {1'b1, 2'd2, 2'd1}, {1'b1, 2'd3, 2'd1}, {1'b0, 2'd2, 2'd1}, {1'b0, 2'd1, 2'd1},
    {1'b1, 2'd0, 2'd1}, {1'b1, 2'd2, 2'd0}, {1'b1, 2'd3, 2'd0}, {1'b1, 2'd2, 2'd2},
    {1'b1, 2'd1, 2'd0}, {1'b0, 2'd3, 2'd0}, {1'b1, 2'd2, 2'd2}, {1'b1, 2'd3, 2'd2}
  };

  task automatic check(input string req, input logic [1:0] exp);
    n_run++;
    if (residue !== exp || residue === 2'b11) begin
      n_fail++;
      $display("FAIL %s: residue=%0d expected=%0d", req, residue, exp);
    end
  endtask

  // drive at falling edge, let one rising edge pass, sample at next falling edge
  task automatic step(input logic r, input logic e, input logic [1:0] op);
    rst = r; acc_en = e; operand = op;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: residue=%0d expected=done", residue);
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    int model;
    rst = 1'b1; acc_en = 1'b0; operand = 2'd0;
    @(negedge clk); @(negedge clk);
    check("R1 reset state", 2'd0);

    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(1'b0, VEC[i][4], VEC[i][3:2]);
      if (VEC[i][3:2] == 2'd3)       check("R3 operand three", VEC[i][1:0]);
      else if (!VEC[i][4])           check("R4 hold when disabled", VEC[i][1:0]);
      else                           check("R2/R7 mod-3 step", VEC[i][1:0]);
    end

    // R7: explicit wrap cases from 2
    step(1'b1, 1'b0, 2'd0);
    step(1'b0, 1'b1, 2'd2);
    step(1'b0, 1'b1, 2'd2); check("R7 2+2 wraps to 1", 2'd1);
    step(1'b0, 1'b1, 2'd1); check("R7 1+1 gives 2", 2'd2);
    step(1'b0, 1'b1, 2'd1); check("R7 2+1 wraps to 0", 2'd0);

    // R5: inputs change between edges, output stays put
    step(1'b0, 1'b1, 2'd2); check("R2 load 2", 2'd2);
    rst = 1'b0; acc_en = 1'b1; operand = 2'd1;
    #1 check("R5 no change before edge", 2'd2);
    operand = 2'd2;
    #1 check("R5 still no change before edge", 2'd2);
    @(negedge clk); check("R5 registered update", 2'd1);

    // R1: reset wins over enable
    step(1'b1, 1'b1, 2'd1); check("R1 reset over enable", 2'd0);

    // R2/R6: random stream against running-sum model
    rst = 1'b0; model = 0;
    for (int k = 0; k < 400; k++) begin
      logic       e;
      logic [1:0] o;
      e = 1'($urandom_range(0, 3) != 0);
      o = 2'($urandom_range(0, 3));
      step(1'b0, e, o);
      if (e) model = (model + int'(o)) % 3;
      check("R2/R6 random model", 2'(model));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule